// File: doc/BRIEF.md
# LIN Master Header Generator

This block drives the start of a LIN frame onto a serial transmit line. Software raises a one-cycle send request. The block then emits a header of one of three kinds: a break on its own, a break followed by the sync character, or a break, the sync character and the protected identifier. The break length and the high delimiter that follows the break are both programmable in bit times. The two identifier parity bits can come from the programmed identifier or from the block itself.

All timing runs from a bit-time strobe `bit_tick`, which pulses for one clock per bit time. Baud generation happens outside the block. While a header is on the line, the block compares the looped-back receive line against the bit it is driving. When the two differ, it raises a sticky bit-error flag and a LIN interrupt. Software clears the flag by pulsing `berr_clr`.

The request bit stays high for the whole header and drops by itself once the last bit time of the chosen header has ended.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, `tx_out` is 1, and `hdr_busy`, `berr_flag` and `lin_irq` are 0.
- R2: The break drives `tx_out` low for `brk_len`+1 bit times.
- R3: After the break, `tx_out` is high for `dlm_len`+1 bit times (delimiter code 0..3 gives 1..4 bit times).
- R4: `hdr_sel` selects the header content: 0 sends break+delimiter, 1 adds the sync character, 2 adds the sync and identifier characters. A request made while `hdr_sel` is 3 is ignored: `hdr_busy` stays 0 and `tx_out` stays 1.
- R5: The sync character is 0x55 framed 8N1: a 0 start bit, then the data LSB first, then a 1 stop bit, one bit time each.
- R6: The identifier character is framed like the sync and sent LSB first. With `id_par_en` = 1, bit 6 is `frame_id`[0]^[1]^[2]^[4] and bit 7 is the inverse of `frame_id`[1]^[3]^[4]^[5]. With `id_par_en` = 0, all 8 bits of `frame_id` are sent unchanged.
- R7: `send_req` sets `hdr_busy` on the next clock when no header is pending. `hdr_busy` clears on the bit-time edge that ends the last bit of the header. A `send_req` while `hdr_busy` is 1 has no effect.
- R8: The break starts at the first `bit_tick` edge after `hdr_busy` is set. The break length, delimiter, identifier and parity enable are sampled at that edge. The header select is sampled with the request.
- R9: With `berr_en` = 1, a `bit_tick` edge during a header at which `rx_in` differs from `tx_out` sets `berr_flag`. With `berr_en` = 0, no flag is set. `lin_irq` equals `berr_flag`.
- R10: `berr_flag` stays set until a `berr_clr` pulse clears it. When a set and a clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock strobe per bit time |
| send_req | input | 1 | Pulse to request a header |
| hdr_sel | input | 2 | Header content select |
| brk_len | input | 4 | Break length minus one, in bit times |
| dlm_len | input | 2 | Delimiter length minus one, in bit times |
| frame_id | input | 8 | Identifier field, ID0 in bit 0 |
| id_par_en | input | 1 | Hardware identifier parity enable |
| berr_en | input | 1 | Bit-error detection enable |
| berr_clr | input | 1 | Write-one clear of the bit-error flag |
| rx_in | input | 1 | Receive line readback |
| tx_out | output | 1 | Serial transmit line |
| hdr_busy | output | 1 | Send request, self-clearing |
| berr_flag | output | 1 | Sticky bit-error flag |
| lin_irq | output | 1 | LIN interrupt |

## Verification
`hdr_busy` rises one clock after the edge that samples `send_req`. Each `tx_out` bit appears one clock after the `bit_tick` edge that starts it and holds until the clock after the next tick. `berr_flag` and `lin_irq` move one clock after the tick edge whose comparison failed. A behavioural model in the bench updates on the same edge that the design does, using a queue of the bits still to be sent. The bench compares all four outputs against this model on every falling edge, half a clock after each register has settled. Error injection and clear pulses are aligned to a known tick edge, so the edge on which a set and a clear collide is fixed in advance.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    localparam int BRK_W  = 4;
    localparam int DLM_W  = 2;
    localparam int SEL_W  = 2;
    localparam int ID_W   = 8;
    localparam int CNT_W  = (BRK_W > 4) ? BRK_W : 4;

    localparam logic [SEL_W-1:0] SEL_BRK    = 2'd0;
    localparam logic [SEL_W-1:0] SEL_SYNC   = 2'd1;
    localparam logic [SEL_W-1:0] SEL_FULL   = 2'd2;
    localparam logic [SEL_W-1:0] SEL_RXONLY = 2'd3;

    localparam logic [ID_W-1:0]  SYNC_BYTE  = 8'h55;
    localparam logic [CNT_W-1:0] CHAR_LAST  = CNT_W'(ID_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BRK,
        ST_DLM,
        ST_SYNC,
        ST_PID
    } hdr_st_e;

    typedef struct packed {
        logic [BRK_W-1:0] brk;
        logic [DLM_W-1:0] dlm;
        logic [ID_W-1:0]  pid;
    } hdr_cfg_t;

    // Protected identifier: low six bits kept, top two replaced when enabled.
    function automatic logic [ID_W-1:0] pid_fill(input logic [ID_W-1:0] id,
                                                  input logic en);
        logic p0;
        logic p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return en ? {p1, p0, id[5:0]} : id;
    endfunction

    // Bit of an 8N1 character at position idx (0 start, 1..8 data, 9 stop).
    function automatic logic char_bit(input logic [ID_W-1:0] data,
                                      input logic [CNT_W-1:0] idx);
        logic [CNT_W-1:0] pos;
        pos = idx - CNT_W'(1);
        if (idx == '0)
            return 1'b0;
        else if (idx <= CNT_W'(ID_W))
            return data[pos[2:0]];
        else
            return 1'b1;
    endfunction

endpackage

// File: rtl/lin_hdr_req.sv
module lin_hdr_req
    import lin_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             done_i,
    output logic             req_o,
    output logic [SEL_W-1:0] sel_o
);

    logic             req_q;
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            sel_q <= SEL_BRK;
        end else if (done_i) begin
            req_q <= 1'b0;
        end else if (set_i && !req_q && (sel_i != SEL_RXONLY)) begin
            req_q <= 1'b1;
            sel_q <= sel_i;
        end
    end

    assign req_o = req_q;
    assign sel_o = sel_q;

    // R4: a receive-only select never raises the request
    a_r4_rx_only_ignored: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> ($past(sel_i) != SEL_RXONLY && $past(set_i)));

    // R7: the request only drops when the sequencer reports completion
    a_r7_clear_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(req_q) |-> $past(done_i));

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
    import lin_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             req_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [BRK_W-1:0] brk_len_i,
    input  logic [DLM_W-1:0] dlm_len_i,
    input  logic [ID_W-1:0]  id_i,
    input  logic             par_en_i,
    output logic             tx_o,
    output logic             active_o,
    output logic             done_o
);

    hdr_st_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    hdr_cfg_t         cfg_q, cfg_d;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        cfg_d  = cfg_q;
        done_o = 1'b0;
        if (tick_i) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_i) begin
                        st_d      = ST_BRK;
                        cnt_d     = '0;
                        cfg_d.brk = brk_len_i;
                        cfg_d.dlm = dlm_len_i;
                        cfg_d.pid = pid_fill(id_i, par_en_i);
                    end
                end
                ST_BRK: begin
                    if (cnt_q == CNT_W'(cfg_q.brk)) begin
                        st_d  = ST_DLM;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_DLM: begin
                    if (cnt_q == CNT_W'(cfg_q.dlm)) begin
                        cnt_d = '0;
                        if (sel_i == SEL_BRK) begin
                            st_d   = ST_IDLE;
                            done_o = 1'b1;
                        end else begin
                            st_d = ST_SYNC;
                        end
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_SYNC: begin
                    if (cnt_q == CHAR_LAST) begin
                        cnt_d = '0;
                        if (sel_i == SEL_SYNC) begin
                            st_d   = ST_IDLE;
                            done_o = 1'b1;
                        end else begin
                            st_d = ST_PID;
                        end
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_PID: begin
                    if (cnt_q == CHAR_LAST) begin
                        cnt_d  = '0;
                        st_d   = ST_IDLE;
                        done_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            cfg_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_BRK:  tx_o = 1'b0;
            ST_DLM:  tx_o = 1'b1;
            ST_SYNC: tx_o = char_bit(SYNC_BYTE, cnt_q);
            ST_PID:  tx_o = char_bit(cfg_q.pid, cnt_q);
            default: tx_o = 1'b1;
        endcase
    end

    assign active_o = (st_q != ST_IDLE);

    // R8: a header leaves idle only on a bit-time strobe with a request pending
    a_r8_start_on_tick: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_IDLE && $past(st_q) == ST_IDLE) |-> ($past(tick_i) && $past(req_i)));

endmodule

// File: rtl/lin_hdr_berr.sv
module lin_hdr_berr
    import lin_hdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic active_i,
    input  logic tx_i,
    input  logic rx_i,
    input  logic en_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;
    logic set_w;

    assign set_w = tick_i && active_i && en_i && (rx_i != tx_i);

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_w)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R10: without a clear, a set flag stays set
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_i) |=> flag_q);

    // R9: the flag rises only on an enabled bit-time strobe
    a_r9_set_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> ($past(en_i) && $past(tick_i)));

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
    import lin_hdr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  logic             send_req,
    input  logic [SEL_W-1:0] hdr_sel,
    input  logic [BRK_W-1:0] brk_len,
    input  logic [DLM_W-1:0] dlm_len,
    input  logic [ID_W-1:0]  frame_id,
    input  logic             id_par_en,
    input  logic             berr_en,
    input  logic             berr_clr,
    input  logic             rx_in,
    output logic             tx_out,
    output logic             hdr_busy,
    output logic             berr_flag,
    output logic             lin_irq
);

    logic             req_w;
    logic [SEL_W-1:0] sel_w;
    logic             done_w;
    logic             active_w;
    logic             tx_w;
    logic             flag_w;

    lin_hdr_req u_req (
        .clk    (clk),
        .rst    (rst),
        .set_i  (send_req),
        .sel_i  (hdr_sel),
        .done_i (done_w),
        .req_o  (req_w),
        .sel_o  (sel_w)
    );

    lin_hdr_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (bit_tick),
        .req_i     (req_w),
        .sel_i     (sel_w),
        .brk_len_i (brk_len),
        .dlm_len_i (dlm_len),
        .id_i      (frame_id),
        .par_en_i  (id_par_en),
        .tx_o      (tx_w),
        .active_o  (active_w),
        .done_o    (done_w)
    );

    lin_hdr_berr u_berr (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (bit_tick),
        .active_i (active_w),
        .tx_i     (tx_w),
        .rx_i     (rx_in),
        .en_i     (berr_en),
        .clr_i    (berr_clr),
        .flag_o   (flag_w)
    );

    assign tx_out    = tx_w;
    assign hdr_busy  = req_w;
    assign berr_flag = flag_w;
    assign lin_irq   = flag_w;

endmodule

// File: tb/tb_lin_hdr_tx.sv
module tb_lin_hdr_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       send_req = 1'b0;
    logic [1:0] hdr_sel = 2'd0;
    logic [3:0] brk_len = 4'd0;
    logic [1:0] dlm_len = 2'd0;
    logic [7:0] frame_id = 8'd0;
    logic       id_par_en = 1'b0;
    logic       berr_en = 1'b0;
    logic       berr_clr = 1'b0;
    logic       inject = 1'b0;
    logic       rx_in;
    logic       tx_out, hdr_busy, berr_flag, lin_irq;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    always #2.5 clk = ~clk;

    assign rx_in = tx_out ^ inject;

    lin_hdr_tx dut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .send_req(send_req),
        .hdr_sel(hdr_sel), .brk_len(brk_len), .dlm_len(dlm_len),
        .frame_id(frame_id), .id_par_en(id_par_en), .berr_en(berr_en),
        .berr_clr(berr_clr), .rx_in(rx_in), .tx_out(tx_out),
        .hdr_busy(hdr_busy), .berr_flag(berr_flag), .lin_irq(lin_irq)
    );

    // ---------------- reference model ----------------
    typedef struct packed { logic b; logic [3:0] tag; } mbit_t;
    mbit_t      m_q[$];
    logic       m_req = 0, m_busy = 0, m_flag = 0, m_tx = 1;
    logic [1:0] m_sel = 0;

    function automatic string tag_name(input int t);
        return $sformatf("R%0d", t);
    endfunction

    task automatic push_char(input logic [7:0] v, input logic [3:0] t);
        m_q.push_back({1'b0, t});
        for (int i = 0; i < 8; i++) m_q.push_back({v[i], t});
        m_q.push_back({1'b1, t});
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_req = 0; m_busy = 0; m_flag = 0; m_sel = 0;
            m_q.delete();
        end else begin
            logic old_req, fin, bset;
            logic [7:0] pv;
            old_req = m_req; fin = 0; bset = 0;
            if (m_busy && bit_tick) begin
                if (berr_en && inject) bset = 1;
                void'(m_q.pop_front());
                if (m_q.size() == 0) begin
                    m_busy = 0; m_req = 0; fin = 1;
                end
            end else if (!m_busy && m_req && bit_tick) begin
                for (int i = 0; i <= int'(brk_len); i++) m_q.push_back({1'b0, 4'd2});
                for (int i = 0; i <= int'(dlm_len); i++) m_q.push_back({1'b1, 4'd3});
                if (m_sel != 2'd0) push_char(8'h55, 4'd5);
                if (m_sel == 2'd2) begin
                    pv = frame_id;
                    if (id_par_en) begin
                        pv[6] = frame_id[0] ^ frame_id[1] ^ frame_id[2] ^ frame_id[4];
                        pv[7] = !(frame_id[1] ^ frame_id[3] ^ frame_id[4] ^ frame_id[5]);
                    end
                    push_char(pv, 4'd6);
                end
                m_busy = 1;
            end
            if (!fin && send_req && !old_req && hdr_sel != 2'd3) begin
                m_req = 1; m_sel = hdr_sel;
            end
            if (bset) m_flag = 1;
            else if (berr_clr) m_flag = 0;
        end
        m_tx = (m_q.size() != 0) ? m_q[0].b : 1'b1;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done_run) begin
            chk((m_q.size() != 0) ? tag_name(m_q[0].tag) : "R4", tx_out, m_tx);
            chk("R7", hdr_busy, m_req);
            chk("R9", berr_flag, m_flag);
            chk("R10", lin_irq, m_flag);
        end
    end

    // ---------------- stimulus ----------------
    initial begin : tick_gen
        int tcnt = 0;
        forever begin
            @(negedge clk);
            tcnt = (tcnt + 1) % 4;
            bit_tick = (tcnt == 0);
        end
    end

    task automatic pulse_send(input logic [1:0] s);
        @(negedge clk);
        hdr_sel = s; send_req = 1;
        @(negedge clk);
        send_req = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!m_req && !m_busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input logic [1:0] s, input logic [3:0] b, input logic [1:0] d,
                       input logic [7:0] id, input logic pe);
        brk_len = b; dlm_len = d; frame_id = id; id_par_en = pe;
        pulse_send(s);
        wait_idle();
    endtask

    // Drive inject (and optionally clear) for exactly one tick edge.
    task automatic hit_tick(input logic with_clr);
        @(posedge clk);
        while (!bit_tick) @(posedge clk);
        repeat (4) @(negedge clk);
        inject = 1; berr_clr = with_clr;
        @(negedge clk);
        inject = 0; berr_clr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", tx_out, 1'b1);
        chk("R1", hdr_busy, 1'b0);
        chk("R1", berr_flag, 1'b0);
        chk("R1", lin_irq, 1'b0);
        rst = 0;
        repeat (5) @(negedge clk);

        // R6 parity on, R2/R3/R5 covered by per-cycle compare
        run(2'd2, 4'd12, 2'd0, 8'h3C, 1'b1);
        run(2'd0, 4'd0, 2'd3, 8'h00, 1'b0);
        run(2'd2, 4'd5, 2'd2, 8'hFF, 1'b0);
        run(2'd2, 4'd1, 2'd1, 8'hA7, 1'b1);

        // R2, R3: measure break and delimiter durations in clocks
        begin
            int lowc = 0, highc = 0;
            brk_len = 4'd15; dlm_len = 2'd1;
            pulse_send(2'd1);
            while (tx_out) @(negedge clk);
            while (!tx_out) begin lowc++; @(negedge clk); end
            while (tx_out) begin highc++; @(negedge clk); end
            checks++;
            if (lowc != 64) begin errors++; $display("FAIL R2 actual=%0d expected=64", lowc); end
            checks++;
            if (highc != 8) begin errors++; $display("FAIL R3 actual=%0d expected=8", highc); end
            wait_idle();
        end

        // R4: receive-only select is ignored
        pulse_send(2'd3);
        repeat (12) @(negedge clk);
        chk("R4", hdr_busy, 1'b0);
        chk("R4", tx_out, 1'b1);

        // R7, R8: a second request while busy, with a changed select, has no effect
        brk_len = 4'd2; dlm_len = 2'd0; frame_id = 8'h12; id_par_en = 1;
        pulse_send(2'd2);
        repeat (20) @(negedge clk);
        pulse_send(2'd0);
        brk_len = 4'd9;
        wait_idle();

        // R9: enabled error sets flag and interrupt
        berr_en = 1;
        brk_len = 4'd6; dlm_len = 2'd1;
        pulse_send(2'd1);
        repeat (10) @(negedge clk);
        hit_tick(1'b0);
        wait_idle();
        chk("R9", berr_flag, 1'b1);
        chk("R9", lin_irq, 1'b1);

        // R10: clear pulse
        berr_clr = 1; @(negedge clk); berr_clr = 0; @(negedge clk);
        chk("R10", berr_flag, 1'b0);

        // R9: disabled detection ignores mismatch
        berr_en = 0;
        pulse_send(2'd1);
        repeat (10) @(negedge clk);
        hit_tick(1'b0);
        wait_idle();
        chk("R9", berr_flag, 1'b0);

        // R10: set and clear on the same edge leaves the flag set
        berr_en = 1;
        pulse_send(2'd1);
        repeat (10) @(negedge clk);
        hit_tick(1'b1);
        wait_idle();
        chk("R10", berr_flag, 1'b1);

        done_run = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            done_run = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule